// File: doc/BRIEF.md
# Immediate and Word-Immediate Execution Unit

This block holds a bank of thirty-two 8-bit general-purpose registers and executes the instructions that carry a constant. A decoder upstream provides an operation kind together with a 4-bit register field and an 8-bit constant for the byte operations. For the word add it passes on the raw 16-bit instruction word. The unit pulls the register-pair selector and the scattered constant bits out of that word itself.

Byte operations reach only the upper half of the register bank. The word add treats an even/odd register pair as one 16-bit value and reaches only four such pairs. All results are written back on the clock edge that samples the strobe. Two combinational read ports show any register, so the contents can be checked at the block's edge.

Top module: `imm_exec_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets all 32 registers to zero.
- R2: With `op_valid` high and `op_kind` = 0 (load), the edge writes `op_const` into register 16 + `op_reg`.
- R3: With `op_valid` high and `op_kind` = 1 (OR), the edge writes the bitwise OR of register 16 + `op_reg` and `op_const` back into that register.
- R4: Byte operations never change registers 0 to 15. The target index is always the 4-bit field plus 16.
- R5: With `op_valid` high and `op_kind` = 2 (word add), the pair {R[p+1], R[p]} gets the constant added to it. R[p] is the low byte, and p = 24 + 2 × `word_op[5:4]`.
- R6: The 6-bit word-add constant is {`word_op[7:6]`, `word_op[3:0]`}, with a value from 0 to 63.
- R7: The 16-bit word sum wraps modulo 65536. Its low and high bytes are written on the same edge, and a carry out of the low byte reaches the high byte.
- R8: A word add whose `word_op[15:8]` differs from 8'h96 is ignored and leaves every register unchanged.
- R9: With `op_valid` low, no register changes, whatever the other inputs are.
- R10: `rd_data_a` and `rd_data_b` follow `rd_addr_a` and `rd_addr_b` combinationally, with no clock edge needed.
- R11: `op_kind` = 3 is a no-operation: with `op_valid` high it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Executes one operation at this edge |
| op_kind | input | 2 | 0 load, 1 OR, 2 word add, 3 none |
| op_reg | input | 4 | Byte-operation register field (offset 16) |
| op_const | input | 8 | Byte-operation constant |
| word_op | input | 16 | Raw word-add instruction word |
| rd_addr_a | input | 5 | Read port A register index |
| rd_data_a | output | 8 | Read port A data |
| rd_addr_b | input | 5 | Read port B register index |
| rd_data_b | output | 8 | Read port B data |

## Verification
The assertions assume that `op_kind` and `op_valid` are always driven to known values, and that at most one operation is presented per edge. The bench drives these inputs only at the falling edge and holds them for a whole cycle. The bench also assumes that the read addresses are stable when it samples. It moves them only between clock edges, so that the combinational read path can be checked without an edge in between. The illegal word-instruction prefixes and the idle and no-operation cycles are applied with byte fields and constants that are not zero. A block that wrongly executed them would therefore visibly change a register.

// File: rtl/imm_pkg.sv
package imm_pkg;
    typedef enum logic [1:0] {
        K_LOADI = 2'd0,
        K_ORI   = 2'd1,
        K_ADDW  = 2'd2,
        K_NONE  = 2'd3
    } imm_kind_e;

    localparam logic [7:0] ADDW_PREFIX = 8'h96;
    localparam int BYTE_BASE = 16;
    localparam int PAIR_BASE = 24;
endpackage

// File: rtl/imm_gpr_file.sv
module imm_gpr_file #(
    parameter int NREG = 32,
    parameter int W    = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we0,
    input  logic [AW-1:0] wa0,
    input  logic [W-1:0]  wd0,
    input  logic          we1,
    input  logic [AW-1:0] wa1,
    input  logic [W-1:0]  wd1,
    input  logic [AW-1:0] ra_x,
    output logic [W-1:0]  rd_x,
    input  logic [AW-1:0] ra_y,
    output logic [W-1:0]  rd_y,
    input  logic [AW-1:0] ra_a,
    output logic [W-1:0]  rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_b
);
    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            if (we0) regs[wa0] <= wd0;
            if (we1) regs[wa1] <= wd1;
        end
    end

    always_comb begin
        rd_x = regs[ra_x];
        rd_y = regs[ra_y];
        rd_a = regs[ra_a];
        rd_b = regs[ra_b];
    end

    // R1: the cycle after reset, both read ports show zero
    p_reset_clears_r1: assert property (@(posedge clk)
        $past(rst) |-> (rd_a == '0 && rd_b == '0));

    // R7: the two write ports never collide
    p_ports_distinct_r7: assert property (@(posedge clk) disable iff (rst)
        (we0 && we1) |-> (wa0 != wa1));

    // R2: write port 0 data lands in its register
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (we0 && !(we1 && wa1 == wa0)) |=> (regs[$past(wa0)] == $past(wd0)));
endmodule

// File: rtl/imm_decode.sv
module imm_decode
    import imm_pkg::*;
#(
    parameter int NREG = 32,
    parameter int KW   = 6,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  imm_kind_e     kind,
    input  logic [3:0]    reg_field,
    input  logic [15:0]   word_op,
    output logic          do_load,
    output logic          do_or,
    output logic          do_word,
    output logic [AW-1:0] byte_idx,
    output logic [AW-1:0] pair_lo,
    output logic [AW-1:0] pair_hi,
    output logic [KW-1:0] word_k
);
    logic       prefix_ok;
    logic [1:0] pair_sel;

    assign prefix_ok = (word_op[15:8] == ADDW_PREFIX);
    assign pair_sel  = word_op[5:4];

    always_comb begin
        do_load = 1'b0;
        do_or   = 1'b0;
        do_word = 1'b0;
        unique case (kind)
            K_LOADI: do_load = valid;
            K_ORI:   do_or   = valid;
            K_ADDW:  do_word = valid && prefix_ok;
            K_NONE:  ;
        endcase
    end

    assign byte_idx = AW'(BYTE_BASE) + AW'(reg_field);
    assign pair_lo  = AW'(PAIR_BASE) + AW'({pair_sel, 1'b0});
    assign pair_hi  = pair_lo + AW'(1);
    assign word_k   = KW'({word_op[7:6], word_op[3:0]});

    // R11: at most one operation class per cycle
    p_one_class_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({do_load, do_or, do_word}));

    // R8: wrong prefix never executes
    p_bad_prefix_r8: assert property (@(posedge clk) disable iff (rst)
        (valid && kind == K_ADDW && word_op[15:8] != ADDW_PREFIX) |-> !do_word);

    // R4: byte target is always in the upper half
    p_upper_half_r4: assert property (@(posedge clk) disable iff (rst)
        (do_load || do_or) |-> (byte_idx >= AW'(BYTE_BASE)));

    // R9: nothing executes without the strobe
    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !valid |-> !(do_load || do_or || do_word));
endmodule

// File: rtl/imm_alu.sv
module imm_alu #(
    parameter int NREG = 32,
    parameter int W    = 8,
    parameter int KW   = 6,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          do_load,
    input  logic          do_or,
    input  logic          do_word,
    input  logic [AW-1:0] byte_idx,
    input  logic [AW-1:0] pair_lo,
    input  logic [AW-1:0] pair_hi,
    input  logic [W-1:0]  konst,
    input  logic [KW-1:0] word_k,
    output logic [AW-1:0] rx_addr,
    output logic [AW-1:0] ry_addr,
    input  logic [W-1:0]  rx_data,
    input  logic [W-1:0]  ry_data,
    output logic          we0,
    output logic [AW-1:0] wa0,
    output logic [W-1:0]  wd0,
    output logic          we1,
    output logic [AW-1:0] wa1,
    output logic [W-1:0]  wd1
);
    logic [2*W-1:0] word_sum;

    assign rx_addr  = do_word ? pair_lo : byte_idx;
    assign ry_addr  = pair_hi;
    assign word_sum = {ry_data, rx_data} + (2*W)'(word_k);

    always_comb begin
        we0 = 1'b0;
        wa0 = rx_addr;
        wd0 = '0;
        we1 = 1'b0;
        wa1 = ry_addr;
        wd1 = '0;
        if (do_load) begin
            we0 = 1'b1;
            wd0 = konst;
        end else if (do_or) begin
            we0 = 1'b1;
            wd0 = rx_data | konst;
        end else if (do_word) begin
            we0 = 1'b1;
            wd0 = word_sum[W-1:0];
            we1 = 1'b1;
            wd1 = word_sum[2*W-1:W];
        end
    end

    // R7: a word add writes both halves of one adjacent pair together
    p_pair_together_r7: assert property (@(posedge clk) disable iff (rst)
        do_word |-> (we0 && we1 && wa1 == wa0 + AW'(1) && wa0[0] == 1'b0));

    // R3: the OR result never clears a bit the register held
    p_or_keeps_bits_r3: assert property (@(posedge clk) disable iff (rst)
        do_or |-> ((wd0 & rx_data) == rx_data));
endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
    import imm_pkg::*;
#(
    parameter int NREG = 32,
    parameter int W    = 8,
    parameter int KW   = 6,
    localparam int AW  = $clog2(NREG)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [1:0]  op_kind,
    input  logic [3:0]  op_reg,
    input  logic [7:0]  op_const,
    input  logic [15:0] word_op,
    input  logic [4:0]  rd_addr_a,
    output logic [7:0]  rd_data_a,
    input  logic [4:0]  rd_addr_b,
    output logic [7:0]  rd_data_b
);
    imm_kind_e     kind;
    logic          do_load, do_or, do_word;
    logic [AW-1:0] byte_idx, pair_lo, pair_hi;
    logic [KW-1:0] word_k;
    logic [AW-1:0] rx_addr, ry_addr;
    logic [W-1:0]  rx_data, ry_data;
    logic          we0, we1;
    logic [AW-1:0] wa0, wa1;
    logic [W-1:0]  wd0, wd1;

    assign kind = imm_kind_e'(op_kind);

    imm_decode #(.NREG(NREG), .KW(KW)) u_dec (
        .clk(clk), .rst(rst), .valid(op_valid), .kind(kind),
        .reg_field(op_reg), .word_op(word_op),
        .do_load(do_load), .do_or(do_or), .do_word(do_word),
        .byte_idx(byte_idx), .pair_lo(pair_lo), .pair_hi(pair_hi),
        .word_k(word_k)
    );

    imm_alu #(.NREG(NREG), .W(W), .KW(KW)) u_alu (
        .clk(clk), .rst(rst),
        .do_load(do_load), .do_or(do_or), .do_word(do_word),
        .byte_idx(byte_idx), .pair_lo(pair_lo), .pair_hi(pair_hi),
        .konst(W'(op_const)), .word_k(word_k),
        .rx_addr(rx_addr), .ry_addr(ry_addr),
        .rx_data(rx_data), .ry_data(ry_data),
        .we0(we0), .wa0(wa0), .wd0(wd0),
        .we1(we1), .wa1(wa1), .wd1(wd1)
    );

    imm_gpr_file #(.NREG(NREG), .W(W)) u_rf (
        .clk(clk), .rst(rst),
        .we0(we0), .wa0(wa0), .wd0(wd0),
        .we1(we1), .wa1(wa1), .wd1(wd1),
        .ra_x(rx_addr), .rd_x(rx_data),
        .ra_y(ry_addr), .rd_y(ry_data),
        .ra_a(AW'(rd_addr_a)), .rd_a(rd_data_a),
        .ra_b(AW'(rd_addr_b)), .rd_b(rd_data_b)
    );
endmodule

// File: tb/sim_imm_exec_unit.sv
`timescale 1ns/1ps
module sim_imm_exec_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'd3;
    logic [3:0]  op_reg = '0;
    logic [7:0]  op_const = '0;
    logic [15:0] word_op = '0;
    logic [4:0]  rd_addr_a = '0;
    logic [7:0]  rd_data_a;
    logic [4:0]  rd_addr_b = '0;
    logic [7:0]  rd_data_b;

    logic [7:0] mdl [32];
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    imm_exec_unit u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_reg(op_reg), .op_const(op_const), .word_op(word_op),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
    );

    function automatic logic [15:0] mk_addw(input logic [1:0] sel, input logic [5:0] k);
        return {8'h96, k[5:4], sel, k[3:0]};
    endfunction

    // compares all 32 registers through port A; one check
    task automatic check_all(input string tag);
        int bad = 0;
        n_run++;
        for (int i = 0; i < 32; i++) begin
            rd_addr_a = 5'(i);
            #0.1;
            if (rd_data_a !== mdl[i] && bad == 0) begin
                $display("FAIL %s: R%0d actual %02h expected %02h", tag, i, rd_data_a, mdl[i]);
                bad = 1;
            end
        end
        if (bad != 0) n_fail++;
    endtask

    task automatic issue(input logic v, input logic [1:0] kd, input logic [3:0] rg,
                         input logic [7:0] c, input logic [15:0] wo);
        @(negedge clk);
        op_valid = v; op_kind = kd; op_reg = rg; op_const = c; word_op = wo;
        @(negedge clk);
        op_valid = 1'b0; op_kind = 2'd3;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        check_all("R1 reset");
    endtask

    task automatic t_load;
        for (int f = 0; f < 16; f++) begin
            issue(1'b1, 2'd0, 4'(f), 8'(8'h30 + f * 13), 16'h0000);
            mdl[16 + f] = 8'(8'h30 + f * 13);
        end
        check_all("R2 load all fields");
        check_all("R4 low half untouched");
        issue(1'b1, 2'd0, 4'd5, 8'hFF, 16'h0000);
        mdl[21] = 8'hFF;
        issue(1'b1, 2'd0, 4'd6, 8'h00, 16'h0000);
        mdl[22] = 8'h00;
        check_all("R2 constant extremes");
    endtask

    task automatic t_or;
        issue(1'b1, 2'd0, 4'd0, 8'hA0, 16'h0);
        mdl[16] = 8'hA0;
        issue(1'b1, 2'd1, 4'd0, 8'h05, 16'h0);
        mdl[16] = 8'hA5;
        issue(1'b1, 2'd1, 4'd15, 8'h81, 16'h0);
        mdl[31] = mdl[31] | 8'h81;
        issue(1'b1, 2'd1, 4'd0, 8'h00, 16'h0);
        check_all("R3 OR immediate");
        check_all("R4 OR stays in upper half");
    endtask

    task automatic t_word;
        for (int s = 0; s < 4; s++) begin
            logic [15:0] v;
            logic [5:0] k;
            k = 6'(17 * s + 9);
            v = {mdl[25 + 2 * s], mdl[24 + 2 * s]} + 16'(k);
            issue(1'b1, 2'd2, 4'd0, 8'h00, mk_addw(2'(s), k));
            mdl[24 + 2 * s] = v[7:0];
            mdl[25 + 2 * s] = v[15:8];
        end
        check_all("R5 word add each pair");
        begin
            logic [15:0] v;
            v = {mdl[29], mdl[28]} + 16'd63;
            issue(1'b1, 2'd2, 4'd0, 8'h00, mk_addw(2'd2, 6'd63));
            mdl[28] = v[7:0]; mdl[29] = v[15:8];
            v = {mdl[25], mdl[24]} + 16'd48;
            issue(1'b1, 2'd2, 4'd0, 8'h00, mk_addw(2'd0, 6'd48));
            mdl[24] = v[7:0]; mdl[25] = v[15:8];
        end
        check_all("R6 scattered constant bits");
    endtask

    task automatic t_wrap;
        issue(1'b1, 2'd0, 4'd14, 8'hFF, 16'h0);
        issue(1'b1, 2'd0, 4'd15, 8'hFF, 16'h0);
        issue(1'b1, 2'd2, 4'd0, 8'h00, mk_addw(2'd3, 6'd1));
        mdl[30] = 8'h00; mdl[31] = 8'h00;
        check_all("R7 wrap to zero");
        issue(1'b1, 2'd0, 4'd10, 8'hF0, 16'h0);
        issue(1'b1, 2'd0, 4'd11, 8'h12, 16'h0);
        issue(1'b1, 2'd2, 4'd0, 8'h00, mk_addw(2'd1, 6'h20));
        mdl[26] = 8'h10; mdl[27] = 8'h13;
        check_all("R7 carry into high byte");
    endtask

    task automatic t_bad_prefix;
        issue(1'b1, 2'd2, 4'd3, 8'h77, 16'h9700 | mk_addw(2'd0, 6'd5) & 16'h00FF);
        issue(1'b1, 2'd2, 4'd3, 8'h77, 16'h1600 | 16'h003F);
        check_all("R8 wrong prefix ignored");
    endtask

    task automatic t_idle_nop;
        issue(1'b0, 2'd0, 4'd1, 8'h5A, 16'h0);
        issue(1'b0, 2'd2, 4'd0, 8'h00, mk_addw(2'd0, 6'd7));
        check_all("R9 strobe low ignored");
        issue(1'b1, 2'd3, 4'd1, 8'h5A, mk_addw(2'd0, 6'd7));
        check_all("R11 kind 3 no operation");
    endtask

    task automatic t_async;
        @(negedge clk);
        #0.5;
        rd_addr_b = 5'd16;
        #0.5;
        n_run++;
        if (rd_data_b !== mdl[16]) begin
            n_fail++;
            $display("FAIL R10 port B: actual %02h expected %02h", rd_data_b, mdl[16]);
        end
        rd_addr_b = 5'd31;
        #0.5;
        n_run++;
        if (rd_data_b !== mdl[31]) begin
            n_fail++;
            $display("FAIL R10 port B change: actual %02h expected %02h", rd_data_b, mdl[31]);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load();
        t_or();
        t_word();
        t_wrap();
        t_bad_prefix();
        t_idle_nop();
        t_async();
        t_reset();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule